// File: doc/BRIEF.md
# Legacy memory region attribute decoder

This block sits in the address path of a chipset and decides where each CPU memory access between 640 KiB and 1 MiB should go. It keeps a handful of byte-wide configuration registers, loaded and read back through a narrow configuration port that takes an 8-bit offset, 8-bit data and a write strobe. Each access presents a 32-bit physical address, a write flag and an indication of whether system management mode is active. The block answers with one of three targets: local DRAM, the legacy expansion bus, or drop.

The option-ROM area from 0xC0000 up to 0xEFFFF is cut into twelve 16 KiB segments. The BIOS area from 0xF0000 up to 0xFFFFF is a single 64 KiB segment. Each segment has its own 2-bit attribute that can open it to DRAM for both directions, open it to DRAM for reads only, or leave it on the expansion bus. The 128 KiB video area below that is normally on the expansion bus. A control byte can open it to DRAM, either unconditionally or only while system management mode is active. The target is combinational, so a configuration write is seen by the very next access.

Top module: `lmr_decoder`

## Requirements
- R1: After reset, offsets 0x59 to 0x5F read back 0x00 and offset 0x72 reads back 0x02. Every option-ROM segment, the BIOS segment and the video area then route to the legacy bus, whatever the SMM input is.
- R2: Target encoding on `acc_target` is 2'b00 for DRAM, 2'b01 for the legacy bus and 2'b10 for drop. Any address below 0xA0000, and any at or above 0x100000, routes to DRAM for reads and for writes.
- R3: The BIOS segment 0xF0000 to 0xFFFFF takes its attribute from bits [5:4] of offset 0x59. The other bits of that byte have no effect on routing.
- R4: Option-ROM segment i (0 to 11) covers 0xC0000 + i*0x4000 up to the next 16 KiB boundary. Its attribute sits in offset 0x5A + i/2, in bits [1:0] for even i and in bits [5:4] for odd i.
- R5: Attribute code 3 routes the segment to DRAM for reads and writes. Codes 0 and 2 route it to the legacy bus for reads and writes.
- R6: With attribute code 1, a read of the segment routes to DRAM and a write routes to drop. Drop is never given for a read.
- R7: When bit 6 of offset 0x72 is set, the video area 0xA0000 to 0xBFFFF routes to DRAM for reads and writes, whether or not SMM is active.
- R8: When bit 6 of 0x72 is clear, the video area routes to DRAM only while SMM is active and bit 3 of 0x72 is set. Otherwise it routes to the legacy bus. The video area is never dropped.
- R9: A configuration write to 0x59 to 0x5F or to 0x72 changes the routing from the first access after the clock edge that takes the write.
- R10: A configuration read returns the full stored byte at offsets 0x59 to 0x5F and 0x72, and 0x00 at every other offset. Writes to other offsets change neither readback nor routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data at `cfg_addr` (combinational) |
| acc_addr | input | 32 | Physical address of the current access |
| acc_write | input | 1 | Access is a write when high |
| smm_active | input | 1 | System management mode is active |
| acc_target | output | 2 | Routing target: 00 DRAM, 01 legacy bus, 10 drop |

## Verification
Every piece of stored state can be seen directly through configuration readback. A corrupted attribute or control byte also shows on `acc_target` at once, when an access lands in the segment it governs. A wrong nibble or byte selection shows up as a neighbouring segment taking the attribute meant for another, so the checks set one segment at a time and probe both it and its partner in the same byte. A missed or late register update appears as stale routing on the first access after the write, and that is where the checks sample.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    typedef enum logic [1:0] {
        TGT_DRAM   = 2'b00,
        TGT_LEGACY = 2'b01,
        TGT_DROP   = 2'b10
    } tgt_e;

    typedef enum logic [1:0] {
        ATTR_BUS_A  = 2'd0,
        ATTR_RDONLY = 2'd1,
        ATTR_BUS_B  = 2'd2,
        ATTR_FULL   = 2'd3
    } attr_e;

    typedef enum logic [2:0] {
        RGN_LOW    = 3'd0,
        RGN_VIDEO  = 3'd1,
        RGN_OPTROM = 3'd2,
        RGN_BIOS   = 3'd3,
        RGN_HIGH   = 3'd4
    } rgn_e;

    localparam int SEG_IDX_W = 4;

    typedef struct packed {
        rgn_e                 rgn;
        logic [SEG_IDX_W-1:0] seg;
    } hit_t;

    function automatic tgt_e attr_route(attr_e a, logic is_wr);
        tgt_e t;
        case (a)
            ATTR_FULL:   t = TGT_DRAM;
            ATTR_RDONLY: t = is_wr ? TGT_DROP : TGT_DRAM;
            default:     t = TGT_LEGACY;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs #(
    parameter logic [7:0] ATTR_BASE  = 8'h59,
    parameter int         ATTR_BYTES = 7,
    parameter logic [7:0] SMR_OFS    = 8'h72,
    parameter logic [7:0] SMR_RST    = 8'h02
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [7:0]                 addr,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rdata,
    output logic [ATTR_BYTES-1:0][7:0] attr_q,
    output logic [7:0]                 smr_q
);

    logic [ATTR_BYTES-1:0] attr_sel;
    logic                  smr_sel;
    logic                  addr_hit;

    for (genvar g = 0; g < ATTR_BYTES; g++) begin : g_attr
        assign attr_sel[g] = (addr == ATTR_BASE + 8'(g));

        always_ff @(posedge clk) begin
            if (rst)                     attr_q[g] <= 8'h00;
            else if (wr_en && attr_sel[g]) attr_q[g] <= wdata;
        end
    end

    assign smr_sel  = (addr == SMR_OFS);
    assign addr_hit = smr_sel || (|attr_sel);

    always_ff @(posedge clk) begin
        if (rst)                 smr_q <= SMR_RST;
        else if (wr_en && smr_sel) smr_q <= wdata;
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < ATTR_BYTES; i++) begin
            if (attr_sel[i]) rdata = attr_q[i];
        end
        if (smr_sel) rdata = smr_q;
    end

    // R10: a byte written at an implemented offset reads back unchanged
    a_r10_readback: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_hit) |=> (addr != $past(addr) || rdata == $past(wdata)));

    // R9: stored state only moves when a write is strobed
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(smr_q) && $stable(attr_q)));

endmodule

// File: rtl/lmr_region_decode.sv
module lmr_region_decode
    import lmr_pkg::*;
#(
    parameter logic [31:0] VID_BASE  = 32'h000A_0000,
    parameter logic [31:0] OPT_BASE  = 32'h000C_0000,
    parameter int          SEG_LOG2  = 14,
    parameter int          NUM_SEG   = 12,
    parameter int          BIOS_LOG2 = 16
) (
    input  logic [31:0] addr,
    output hit_t        hit
);

    localparam logic [31:0] BIOS_BASE = OPT_BASE + (32'(NUM_SEG) << SEG_LOG2);
    localparam logic [31:0] TOP_ADDR  = BIOS_BASE + (32'd1 << BIOS_LOG2);

    logic [31:0] opt_off;

    assign opt_off = addr - OPT_BASE;

    always_comb begin
        hit.seg = '0;
        if (addr < VID_BASE) begin
            hit.rgn = RGN_LOW;
        end else if (addr < OPT_BASE) begin
            hit.rgn = RGN_VIDEO;
        end else if (addr < BIOS_BASE) begin
            hit.rgn = RGN_OPTROM;
            hit.seg = opt_off[SEG_LOG2 +: SEG_IDX_W];
        end else if (addr < TOP_ADDR) begin
            hit.rgn = RGN_BIOS;
        end else begin
            hit.rgn = RGN_HIGH;
        end
    end

endmodule

// File: rtl/lmr_attr_select.sv
module lmr_attr_select
    import lmr_pkg::*;
#(
    parameter int NUM_SEG    = 12,
    parameter int ATTR_BYTES = 1 + (NUM_SEG + 1) / 2
) (
    input  logic [ATTR_BYTES-1:0][7:0] attr_q,
    input  hit_t                       hit,
    output attr_e                      attr
);

    logic [NUM_SEG-1:0][1:0] seg_attr;

    // byte 0 holds the BIOS field; segment pairs follow, even low, odd high
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        if ((i % 2) == 0) begin : g_even
            assign seg_attr[i] = attr_q[1 + i / 2][1:0];
        end else begin : g_odd
            assign seg_attr[i] = attr_q[1 + i / 2][5:4];
        end
    end

    always_comb begin
        attr = ATTR_BUS_A;
        case (hit.rgn)
            RGN_BIOS: attr = attr_e'(attr_q[0][5:4]);
            RGN_OPTROM: begin
                for (int i = 0; i < NUM_SEG; i++) begin
                    if (hit.seg == SEG_IDX_W'(i)) attr = attr_e'(seg_attr[i]);
                end
            end
            default: attr = ATTR_BUS_A;
        endcase
    end

endmodule

// File: rtl/lmr_decoder.sv
module lmr_decoder
    import lmr_pkg::*;
#(
    parameter logic [7:0]  ATTR_BASE  = 8'h59,
    parameter logic [7:0]  SMR_OFS    = 8'h72,
    parameter logic [7:0]  SMR_RST    = 8'h02,
    parameter int          NUM_SEG    = 12,
    parameter int          SEG_LOG2   = 14,
    parameter int          FORCE_BIT  = 6,
    parameter int          SMM_BIT    = 3,
    parameter logic [31:0] VID_BASE   = 32'h000A_0000,
    parameter logic [31:0] OPT_BASE   = 32'h000C_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_write,
    input  logic        smm_active,
    output logic [1:0]  acc_target
);

    localparam int ATTR_BYTES = 1 + (NUM_SEG + 1) / 2;

    logic [ATTR_BYTES-1:0][7:0] attr_q;
    logic [7:0]                 smr_q;
    hit_t                       hit;
    attr_e                      attr;
    tgt_e                       tgt;
    logic                       vid_open;

    lmr_cfg_regs #(
        .ATTR_BASE (ATTR_BASE),
        .ATTR_BYTES(ATTR_BYTES),
        .SMR_OFS   (SMR_OFS),
        .SMR_RST   (SMR_RST)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .attr_q(attr_q),
        .smr_q (smr_q)
    );

    lmr_region_decode #(
        .VID_BASE(VID_BASE),
        .OPT_BASE(OPT_BASE),
        .SEG_LOG2(SEG_LOG2),
        .NUM_SEG (NUM_SEG)
    ) u_region (
        .addr(acc_addr),
        .hit (hit)
    );

    lmr_attr_select #(
        .NUM_SEG   (NUM_SEG),
        .ATTR_BYTES(ATTR_BYTES)
    ) u_attr (
        .attr_q(attr_q),
        .hit   (hit),
        .attr  (attr)
    );

    assign vid_open = smr_q[FORCE_BIT] || (smm_active && smr_q[SMM_BIT]);

    always_comb begin
        case (hit.rgn)
            RGN_VIDEO:           tgt = vid_open ? TGT_DRAM : TGT_LEGACY;
            RGN_OPTROM, RGN_BIOS: tgt = attr_route(attr, acc_write);
            default:             tgt = TGT_DRAM;
        endcase
    end

    assign acc_target = tgt;

    // R2: outside the legacy window every access lands in DRAM
    a_r2_outside_dram: assert property (@(posedge clk) disable iff (rst)
        (acc_addr < 32'h000A_0000 || acc_addr >= 32'h0010_0000) |-> acc_target == 2'b00);

    // R6: drop is reserved for writes
    a_r6_drop_needs_write: assert property (@(posedge clk) disable iff (rst)
        (acc_target == 2'b10) |-> acc_write);

    // R8: the video window is never dropped
    a_r8_video_no_drop: assert property (@(posedge clk) disable iff (rst)
        (acc_addr >= 32'h000A_0000 && acc_addr < 32'h000C_0000) |-> acc_target != 2'b10);

    // R7: forced-open control wins over the SMM input
    a_r7_forced_open: assert property (@(posedge clk) disable iff (rst)
        (acc_addr >= 32'h000A_0000 && acc_addr < 32'h000C_0000 && cfg_addr == SMR_OFS
         && cfg_rdata[FORCE_BIT]) |-> acc_target == 2'b00);

    // R5: the target is always one of the three legal codes
    a_r5_legal_target: assert property (@(posedge clk) disable iff (rst)
        acc_target != 2'b11);

endmodule

// File: tb/lmr_decoder_tb.sv
module lmr_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_write = 1'b0;
    logic        smm_active = 1'b0;
    logic [1:0]  acc_target;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [1:0] DRAM = 2'b00;
    localparam logic [1:0] LEG  = 2'b01;
    localparam logic [1:0] DROP = 2'b10;

    always #5 clk = ~clk;

    lmr_decoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .smm_active(smm_active),
        .acc_target(acc_target)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] ofs, logic [7:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = ofs;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic read_chk(string req, logic [7:0] ofs, logic [7:0] exp);
        cfg_addr = ofs;
        #1;
        chk(req, $sformatf("readback @%0h", ofs), {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic route_chk(string req, logic [31:0] a, logic w, logic s, logic [1:0] exp);
        acc_addr   = a;
        acc_write  = w;
        smm_active = s;
        #1;
        chk(req, $sformatf("route a=%0h w=%0b smm=%0b", a, w, s), {30'h0, acc_target}, {30'h0, exp});
    endtask

    task automatic t_reset();
        for (int o = 8'h59; o <= 8'h5F; o++) read_chk("R1", 8'(o), 8'h00);
        read_chk("R1", 8'h72, 8'h02);
        route_chk("R1", 32'h000C_0000, 1'b0, 1'b0, LEG);
        route_chk("R1", 32'h000E_FFFF, 1'b1, 1'b0, LEG);
        route_chk("R1", 32'h000F_8000, 1'b0, 1'b0, LEG);
        route_chk("R1", 32'h000A_0000, 1'b0, 1'b1, LEG);
        route_chk("R1", 32'h000B_FFFF, 1'b1, 1'b0, LEG);
    endtask

    task automatic t_outside();
        cfg_write(8'h72, 8'h00);
        route_chk("R2", 32'h0000_0000, 1'b0, 1'b0, DRAM);
        route_chk("R2", 32'h0009_FFFF, 1'b1, 1'b0, DRAM);
        route_chk("R2", 32'h0010_0000, 1'b1, 1'b1, DRAM);
        route_chk("R2", 32'hFFFF_FFFF, 1'b0, 1'b0, DRAM);
        route_chk("R2", 32'h000A_0000, 1'b0, 1'b0, LEG);
    endtask

    task automatic t_bios();
        cfg_write(8'h59, 8'h30);
        route_chk("R3", 32'h000F_0000, 1'b0, 1'b0, DRAM);
        route_chk("R3", 32'h000F_FFFF, 1'b1, 1'b0, DRAM);
        route_chk("R3", 32'h000E_FFFF, 1'b0, 1'b0, LEG);
        cfg_write(8'h59, 8'h10);
        route_chk("R6", 32'h000F_4000, 1'b0, 1'b0, DRAM);
        route_chk("R6", 32'h000F_4000, 1'b1, 1'b0, DROP);
        cfg_write(8'h59, 8'h20);
        route_chk("R5", 32'h000F_0000, 1'b0, 1'b0, LEG);
        route_chk("R5", 32'h000F_0000, 1'b1, 1'b0, LEG);
        cfg_write(8'h59, 8'hCF);
        route_chk("R3", 32'h000F_C000, 1'b0, 1'b0, LEG);
        cfg_write(8'h59, 8'h00);
    endtask

    task automatic t_segments();
        for (int k = 0; k < 6; k++) begin
            logic [31:0] ev = 32'h000C_0000 + 32'(2 * k) * 32'h4000;
            logic [31:0] od = ev + 32'h4000;
            cfg_write(8'h5A + 8'(k), 8'h03);
            route_chk("R4", ev + 32'h1234, 1'b1, 1'b0, DRAM);
            route_chk("R4", od, 1'b0, 1'b0, LEG);
            cfg_write(8'h5A + 8'(k), 8'h30);
            route_chk("R4", ev + 32'h3FFF, 1'b0, 1'b0, LEG);
            route_chk("R4", od + 32'h3FFF, 1'b1, 1'b0, DRAM);
            cfg_write(8'h5A + 8'(k), 8'h00);
        end
        for (int o = 8'h5A; o <= 8'h5F; o++) cfg_write(8'(o), 8'h31);
        route_chk("R6", 32'h000C_0000, 1'b1, 1'b0, DROP);
        route_chk("R6", 32'h000C_3FFF, 1'b0, 1'b0, DRAM);
        route_chk("R5", 32'h000C_4000, 1'b1, 1'b0, DRAM);
        route_chk("R6", 32'h000E_8000, 1'b1, 1'b1, DROP);
        route_chk("R5", 32'h000E_FFFF, 1'b1, 1'b0, DRAM);
        route_chk("R3", 32'h000F_0000, 1'b1, 1'b0, LEG);
        cfg_write(8'h5D, 8'h02);
        route_chk("R5", 32'h000D_8000, 1'b1, 1'b0, LEG);
        route_chk("R5", 32'h000D_C000, 1'b1, 1'b0, LEG);
        route_chk("R6", 32'h000D_4000, 1'b1, 1'b0, DRAM);
    endtask

    task automatic t_video();
        cfg_write(8'h72, 8'h40);
        route_chk("R7", 32'h000A_0000, 1'b0, 1'b0, DRAM);
        route_chk("R7", 32'h000B_FFFF, 1'b1, 1'b1, DRAM);
        cfg_write(8'h72, 8'h08);
        route_chk("R8", 32'h000A_8000, 1'b0, 1'b0, LEG);
        route_chk("R8", 32'h000A_8000, 1'b1, 1'b1, DRAM);
        cfg_write(8'h72, 8'h48);
        route_chk("R7", 32'h000B_0000, 1'b1, 1'b0, DRAM);
        cfg_write(8'h72, 8'hB7);
        route_chk("R8", 32'h000B_0000, 1'b1, 1'b1, LEG);
        route_chk("R8", 32'h000C_0000, 1'b1, 1'b1, DROP);
    endtask

    task automatic t_next_access();
        @(negedge clk);
        acc_addr  = 32'h000A_4000;
        acc_write = 1'b0;
        smm_active = 1'b0;
        cfg_wr_en = 1'b1;
        cfg_addr  = 8'h72;
        cfg_wdata = 8'h40;
        #1;
        chk("R9", "route before write edge", {30'h0, acc_target}, {30'h0, LEG});
        @(posedge clk);
        #1;
        chk("R9", "route right after write edge", {30'h0, acc_target}, {30'h0, DRAM});
        cfg_wr_en = 1'b0;
        cfg_write(8'h5B, 8'h03);
        route_chk("R9", 32'h000C_8000, 1'b1, 1'b0, DRAM);
    endtask

    task automatic t_readback();
        cfg_write(8'h5C, 8'hA5);
        read_chk("R10", 8'h5C, 8'hA5);
        read_chk("R10", 8'h72, 8'h40);
        cfg_write(8'h60, 8'hFF);
        read_chk("R10", 8'h60, 8'h00);
        cfg_write(8'h58, 8'hFF);
        read_chk("R10", 8'h58, 8'h00);
        cfg_write(8'h73, 8'h00);
        read_chk("R10", 8'h72, 8'h40);
        route_chk("R10", 32'h000F_0000, 1'b0, 1'b0, LEG);
        route_chk("R10", 32'h000A_0000, 1'b0, 1'b0, DRAM);
        read_chk("R10", 8'h00, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_outside();
        t_bios();
        t_segments();
        t_video();
        t_next_access();
        t_readback();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule